// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for every cycle of a four-beat memory burst. A load command captures an external address, the read/write direction and starts a burst; each following advance command steps the two lowest address bits through a four-word pattern while the upper bits stay fixed. The pattern is either linear (counting up modulo four from the starting offset) or interleaved (starting offset XOR beat number), chosen by a mode input that is meant to be tied to a constant.

The burst never ends on its own. After the fourth beat the address returns to the burst's own starting word and keeps cycling for as long as advance is given. A load command issued while the chip is not selected stops the burst, and a suspend input freezes every register for as long as it is high. The memory array that consumes the address sits outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: During and right after reset, `burst_active` is 0, `burst_read` is 0 and `cur_addr` is all zeros.
- R2: With `suspend`=0, `adv_nload`=0 and `chip_sel`=1 at a clock edge, after that edge `burst_active` is 1, `cur_addr` equals the sampled `ext_addr` and `burst_read` equals the sampled `is_read` (1 = read, 0 = write).
- R3: With `order_xor`=0, beat k of a burst has low offset (start + k) mod 4, where start is `ext_addr[1:0]` at load; from start 01 the offsets are 01, 10, 11, 00.
- R4: With `order_xor`=1, beat k has low offset start XOR k; from start 01 the offsets are 01, 00, 11, 10.
- R5: The advance after the fourth beat returns the low offset to the starting offset, and cycling continues for as long as advance is given.
- R6: On advance cycles `ext_addr` has no effect, and the address bits above bit 1 keep the loaded value.
- R7: On advance cycles `is_read` has no effect; `burst_read` keeps the direction captured at load.
- R8: With `suspend`=0, `adv_nload`=0 and `chip_sel`=0, after that edge `burst_active` is 0 and `cur_addr` is all zeros.
- R9: While `suspend`=1 at a clock edge, `burst_active`, `burst_read` and `cur_addr` do not change at that edge, whatever the other inputs do.
- R10: An advance while no burst is active is an idle cycle: `burst_active` stays 0 and `cur_addr` stays all zeros.
- R11: A load during a running burst restarts at beat zero on the new address, whatever beat the old burst had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend | input | 1 | 1 freezes all state at this edge |
| chip_sel | input | 1 | Combined chip select, 1 = selected |
| adv_nload | input | 1 | 0 = load (or stop if deselected), 1 = advance |
| is_read | input | 1 | Direction sampled at load, 1 = read |
| order_xor | input | 1 | Static order select, 1 = interleaved, 0 = linear |
| ext_addr | input | ADDR_W | External word address sampled at load |
| cur_addr | output | ADDR_W | Address of the current beat, zero when idle |
| burst_active | output | 1 | 1 while a burst is running |
| burst_read | output | 1 | Direction of the current burst, 1 = read |

## Verification
A corrupted beat counter shows on the low two bits of `cur_addr` on the very next advance, and because the pattern repeats every four beats a stuck counter bit is visible within four cycles of a long burst. A wrong captured base or direction shows on the cycle right after the load, and a broken suspend or stop path shows as a change of `burst_active` or `cur_addr` one cycle after the command. The bench therefore compares all three outputs on every cycle against its own model, so any divergence surfaces within one clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEATS = 4;
  localparam int OFF_W = $clog2(BEATS);

  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STOP = 2'd2,
    CMD_STEP = 2'd3
  } cmd_e;

  // Offset visited on a given beat for either order.
  function automatic off_t visit_offset(input off_t start, input off_t beat,
                                        input logic interleave);
    off_t sum;
    sum = off_t'(start + beat);
    return interleave ? (start ^ beat) : sum;
  endfunction

  // Command decode; suspend has priority over everything.
  function automatic cmd_e decode_cmd(input logic suspend, input logic sel,
                                      input logic adv);
    if (suspend) return CMD_HOLD;
    if (adv) return CMD_STEP;
    return sel ? CMD_LOAD : CMD_STOP;
  endfunction
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              is_read,
  output logic              active,
  output off_t              beat,
  output logic [ADDR_W-1:0] base,
  output logic              dir_read
);
  logic ev_load, ev_stop, ev_step, ev_idle_step;

  assign ev_load      = (cmd == CMD_LOAD);
  assign ev_stop      = (cmd == CMD_STOP);
  assign ev_step      = (cmd == CMD_STEP) && active;
  assign ev_idle_step = (cmd == CMD_STEP) && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat     <= '0;
      base     <= '0;
      dir_read <= 1'b0;
    end else begin
      if (ev_load) begin
        active   <= 1'b1;
        beat     <= '0;
        base     <= ext_addr;
        dir_read <= is_read;
      end else if (ev_stop) begin
        active <= 1'b0;
      end else if (ev_step) begin
        beat <= beat + off_t'(1);
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> $stable(active) && $stable(beat) && $stable(base) && $stable(dir_read));

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !active);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_step |=> !active && $stable(beat));

  assert_dir_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP) |=> $stable(dir_read) && $stable(base));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> active && (beat == '0));
endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] base,
  input  off_t              beat,
  input  logic              interleave,
  input  logic              active,
  output logic [ADDR_W-1:0] addr
);
  localparam int UP_W = ADDR_W - OFF_W;

  off_t low_off;
  assign low_off = visit_offset(base[OFF_W-1:0], beat, interleave);

  generate
    if (UP_W > 0) begin : g_upper
      assign addr = active ? {base[ADDR_W-1:OFF_W], low_off} : '0;
    end else begin : g_lowonly
      assign addr = active ? low_off[ADDR_W-1:0] : '0;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              chip_sel,
  input  logic              adv_nload,
  input  logic              is_read,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_active,
  output logic              burst_read
);
  cmd_e              cmd;
  logic              st_active;
  off_t              st_beat;
  logic [ADDR_W-1:0] st_base;
  logic              st_dir;

  assign cmd = decode_cmd(suspend, chip_sel, adv_nload);

  bseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .ext_addr (ext_addr),
    .is_read  (is_read),
    .active   (st_active),
    .beat     (st_beat),
    .base     (st_base),
    .dir_read (st_dir)
  );

  bseq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .base       (st_base),
    .beat       (st_beat),
    .interleave (order_xor),
    .active     (st_active),
    .addr       (cur_addr)
  );

  assign burst_active = st_active;
  assign burst_read   = st_dir;

  assert_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !adv_nload && chip_sel) |=>
      burst_active && (cur_addr == $past(ext_addr)) && (burst_read == $past(is_read)));

  assert_lin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv_nload && burst_active && !order_xor) |=>
      (order_xor || (cur_addr[OFF_W-1:0] == off_t'($past(cur_addr[OFF_W-1:0]) + off_t'(1)))));

  assert_upper_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv_nload && burst_active) |=>
      (cur_addr[ADDR_W-1:OFF_W] == $past(cur_addr[ADDR_W-1:OFF_W])));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> $stable(burst_active) && $stable(burst_read));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int PERIOD = 10;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          suspend = 1'b0, chip_sel = 1'b0, adv_nload = 1'b1;
  logic          is_read = 1'b0, order_xor = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          burst_active, burst_read;

  int checks = 0;
  int failures = 0;

  // bench model
  logic          m_act = 1'b0, m_dir = 1'b0;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .chip_sel(chip_sel),
    .adv_nload(adv_nload), .is_read(is_read), .order_xor(order_xor),
    .ext_addr(ext_addr), .cur_addr(cur_addr), .burst_active(burst_active),
    .burst_read(burst_read)
  );

  function automatic logic [1:0] exp_off(logic [1:0] s, int k, logic ilv);
    logic [2:0] sum;
    logic [1:0] kb;
    kb = k[1:0];
    if (ilv) return {s[1] ^ kb[1], s[0] ^ kb[0]};
    sum = {1'b0, s} + {1'b0, kb};
    return sum[1:0];
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    if (!m_act) return '0;
    return {m_base[AW-1:2], exp_off(m_base[1:0], m_beat, order_xor)};
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] ea;
    ea = exp_addr();
    checks++;
    if (cur_addr !== ea || burst_active !== m_act || burst_read !== m_dir) begin
      failures++;
      $display("FAIL %s: addr=%h act=%b rd=%b expected addr=%h act=%b rd=%b",
               tag, cur_addr, burst_active, burst_read, ea, m_act, m_dir);
    end
  endtask

  task automatic cyc(logic s, logic sel, logic adv, logic rd, logic [AW-1:0] a, string tag);
    @(negedge clk);
    suspend = s; chip_sel = sel; adv_nload = adv; is_read = rd; ext_addr = a;
    @(posedge clk);
    if (!s) begin
      if (!adv) begin
        if (sel) begin m_act = 1'b1; m_base = a; m_beat = 0; m_dir = rd; end
        else m_act = 1'b0;
      end else if (m_act) m_beat = (m_beat + 1) % 4;
    end
    #(PERIOD/4);
    check(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1 check("R1 after reset");

    // R10: advance while idle
    cyc(0, 1, 1, 1, 17'h1ABCD, "R10");
    cyc(0, 0, 1, 0, 17'h0FFFF, "R10");

    // R2 + R3 + R5 + R6 + R7: linear from 01
    order_xor = 1'b0;
    cyc(0, 1, 0, 1, 17'h12341, "R2 linear load");
    for (int i = 0; i < 6; i++)
      cyc(0, i[0], 1, i[1], 17'h0AAAA ^ 17'(i), i == 3 ? "R5 linear wrap" : "R3 R6 R7 linear");

    // R4 + R5: interleaved from 01 (write)
    order_xor = 1'b1;
    cyc(0, 1, 0, 0, 17'h05551, "R2 interleaved load");
    for (int i = 0; i < 5; i++)
      cyc(0, 1, 1, 1, 17'h1FFFF, i == 3 ? "R5 interleaved wrap" : "R4 R7 interleaved");

    // R9: suspend with a load offered
    cyc(1, 1, 0, 1, 17'h00003, "R9 suspend load");
    cyc(1, 0, 0, 1, 17'h00000, "R9 suspend stop");
    cyc(1, 1, 1, 1, 17'h00000, "R9 suspend step");

    // R11: reload mid-burst
    cyc(0, 1, 1, 0, 17'h0, "R4 step");
    cyc(0, 1, 0, 1, 17'h1C002, "R11 reload");
    cyc(0, 1, 1, 0, 17'h0, "R11 step");

    // R8: deselect stops burst, then idle steps
    cyc(0, 0, 0, 0, 17'h1C003, "R8 stop");
    cyc(0, 1, 1, 0, 17'h1C003, "R10 after stop");

    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic s, sel, adv, rd;
      string tag;
      if (i % 64 == 0) order_xor = $urandom_range(0, 1);
      s   = ($urandom_range(0, 7) == 0);
      sel = ($urandom_range(0, 7) != 0);
      adv = ($urandom_range(0, 3) != 0);
      rd  = $urandom_range(0, 1);
      if (s) tag = "R9 random";
      else if (!adv && sel) tag = "R2 random";
      else if (!adv) tag = "R8 random";
      else if (!m_act) tag = "R10 random";
      else if (order_xor) tag = "R4 random";
      else tag = "R3 random";
      cyc(s, sel, adv, rd, 17'($urandom), tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule